// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor core that completes every instruction in one clock period. It fetches a word from a small internal instruction store, decodes it, reads two operands from a 32-entry register file, runs one operation through the ALU, and commits its results at the next rising edge. The results are a register write, a data-store write and the new PC. It executes nine instructions: the register-register forms add, sub, and, or and slt; the immediate form ori; the word load lw; the word store sw; and the conditional branch beq.

A load port fills the instruction store while the core is held in reset. Once reset is released the program runs from address 0. Two debug outputs give visibility: the current PC, and a third, combinational register-file read port steered by a select input. Data-store contents are observed by loading them back into registers.

Top module: `sc_core`

## Requirements
- R1: While reset is asserted the PC is 0 and every register reads 0, including registers written before the reset.
- R2: An R-type word (opcode 0x00) writes R[rd] with R[rs] op R[rt] and advances the PC by 4. The funct field selects the op: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or.
- R3: R-type funct 0x2A (set-less-than) writes 1 to R[rd] when R[rs] is below R[rt] as a signed two's-complement value, and 0 otherwise.
- R4: Opcode 0x0D writes R[rt] with R[rs] OR the 16-bit immediate (bits 15:0), zero-extended.
- R5: Opcode 0x23 writes R[rt] with the data word at R[rs] plus the sign-extended immediate. Address bits 1:0 are dropped, and the word index wraps modulo the data-store depth (64 words by default).
- R6: Opcode 0x2B writes R[rt] to the data word at the same address form as R5 and leaves every register unchanged, including the register named by instruction bits 15:11.
- R7: Opcode 0x04 compares R[rs] with R[rt] by subtraction. When they are equal the next PC is PC+4 plus the sign-extended immediate shifted left by 2; otherwise it is PC+4. An offset of -1 holds the PC in place.
- R8: Register 0 always reads 0, and writes that target it are discarded.
- R9: All state changes at one edge. An instruction that reads the register it writes uses the old value, and the next instruction sees the new value.
- R10: An unknown opcode, or an R-type word with an unlisted funct, writes no register and no data word, and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state commits on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of PC and registers |
| prog_we | input | 1 | Instruction-store write enable |
| prog_addr | input | 6 | Instruction-store word index |
| prog_data | input | 32 | Instruction word to store |
| dbg_reg_sel | input | 5 | Register picked for the debug read |
| dbg_reg_data | output | 32 | Current value of the selected register |
| dbg_pc | output | 32 | Current PC |

## Verification
A single instruction can both read and write the same register, and a register written by one instruction is read by the next. The tests provoke this with chains such as `add r1,r1,r1` repeated, and with a store immediately followed by a load from the same address. Each result is judged against values the bench computes step by step. A store whose immediate bits 15:11 name a live register also combines the memory-write path and the register-destination field in one cycle. The bench checks that this register stays untouched and that the stored word can be read back, including a store that lands on an index that wraps modulo the data-store depth.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN  = 32;
  localparam int NREGS = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  // operation class chosen by the main decoder
  typedef enum logic [1:0] {GRP_RTYPE, GRP_OR, GRP_ADD, GRP_SUB} alu_grp_e;
  // final ALU operation after local funct decode
  typedef enum logic [2:0] {ALU_AND, ALU_OR, ALU_ADD, ALU_SUB, ALU_SLT, ALU_NONE} alu_fn_e;

  typedef struct packed {
    logic     dst_rd;
    logic     b_imm;
    logic     ext_sign;
    logic     wb_mem;
    logic     rf_we;
    logic     mem_we;
    logic     branch;
    logic     illegal;
    alu_grp_e grp;
  } ctrl_t;

  function automatic logic [XLEN-1:0] ext_imm(input logic [15:0] imm, input logic sgn);
    return sgn ? {{(XLEN-16){imm[15]}}, imm} : {{(XLEN-16){1'b0}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] br_target(input logic [XLEN-1:0] pc4, input logic [15:0] imm);
    return pc4 + {{(XLEN-18){imm[15]}}, imm, 2'b00};
  endfunction

  function automatic alu_fn_e alu_select(input alu_grp_e grp, input logic [5:0] funct);
    case (grp)
      GRP_OR:  return ALU_OR;
      GRP_ADD: return ALU_ADD;
      GRP_SUB: return ALU_SUB;
      default: begin
        case (funct)
          FN_ADD:  return ALU_ADD;
          FN_SUB:  return ALU_SUB;
          FN_AND:  return ALU_AND;
          FN_OR:   return ALU_OR;
          FN_SLT:  return ALU_SLT;
          default: return ALU_NONE;
        endcase
      end
    endcase
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_fn_e fn, input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    case (fn)
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      ALU_SLT: return {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl         = '0;
    ctrl.grp     = GRP_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        ctrl.rf_we  = 1'b1;
        ctrl.grp    = GRP_RTYPE;
      end
      OP_ORI: begin
        ctrl.b_imm = 1'b1;
        ctrl.rf_we = 1'b1;
        ctrl.grp   = GRP_OR;
      end
      OP_LW: begin
        ctrl.b_imm    = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.wb_mem   = 1'b1;
        ctrl.rf_we    = 1'b1;
      end
      OP_SW: begin
        ctrl.b_imm    = 1'b1;
        ctrl.ext_sign = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.grp    = GRP_SUB;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
(
  input  alu_grp_e        grp,
  input  logic [5:0]      funct,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] res,
  output logic            zero,
  output logic            fn_bad
);
  alu_fn_e fn;

  always_comb begin
    fn     = alu_select(grp, funct);
    res    = alu_eval(fn, a, b);
    zero   = (res == '0);
    fn_bad = (fn == ALU_NONE);
  end

  // R3: a set-less-than result carries only bit 0
  always_comb begin
    if (fn == ALU_SLT) begin
      p_slt_bit_r3: assert (res[XLEN-1:1] == '0);
    end
  end
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
  import sc_pkg::*;
#(
  parameter  int N  = NREGS,
  localparam int AW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   ra_a,
  input  logic [AW-1:0]   ra_b,
  input  logic [AW-1:0]   ra_dbg,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_b,
  output logic [XLEN-1:0] rd_dbg,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd
);
  logic [XLEN-1:0] regs [N];

  function automatic logic [XLEN-1:0] rd_port(input logic [AW-1:0] adr, input logic [XLEN-1:0] val);
    return (adr == '0) ? '0 : val;
  endfunction

  assign rd_a   = rd_port(ra_a, regs[ra_a]);
  assign rd_b   = rd_port(ra_b, regs[ra_b]);
  assign rd_dbg = rd_port(ra_dbg, regs[ra_dbg]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  p_zero_reg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_dbg == '0) |-> (rd_dbg == '0));

  p_write_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wa != '0) |=> (regs[$past(wa)] == $past(wd)));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter  int IMEM_WORDS = 64,
  parameter  int DMEM_WORDS = 64,
  localparam int IA_W = $clog2(IMEM_WORDS),
  localparam int DA_W = $clog2(DMEM_WORDS),
  localparam int RA_W = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            prog_we,
  input  logic [IA_W-1:0] prog_addr,
  input  logic [XLEN-1:0] prog_data,
  input  logic [RA_W-1:0] dbg_reg_sel,
  output logic [XLEN-1:0] dbg_reg_data,
  output logic [XLEN-1:0] dbg_pc
);
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pc, pc4, pc_next, br_dest;
  logic [XLEN-1:0] instr;
  logic [5:0]      f_op, f_funct;
  logic [4:0]      f_rs, f_rt, f_rd;
  logic [15:0]     f_imm;
  ctrl_t           ctrl;
  logic [XLEN-1:0] opa, opb, alu_b, alu_res, mem_rdata, wb_data;
  logic            alu_zero, alu_bad, rf_we_eff, br_taken;
  logic [4:0]      rf_wa;
  logic [DA_W-1:0] d_idx;
  logic            unused_shamt;

  // fetch and field split
  assign instr        = imem[pc[IA_W+1:2]];
  assign f_op         = instr[31:26];
  assign f_rs         = instr[25:21];
  assign f_rt         = instr[20:16];
  assign f_rd         = instr[15:11];
  assign f_funct      = instr[5:0];
  assign f_imm        = instr[15:0];
  assign unused_shamt = ^instr[10:6];

  always_ff @(posedge clk) begin
    if (prog_we) imem[prog_addr] <= prog_data;
  end

  sc_decode u_dec (.opcode(f_op), .ctrl(ctrl));

  sc_regfile u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(f_rs), .ra_b(f_rt), .ra_dbg(dbg_reg_sel),
    .rd_a(opa), .rd_b(opb), .rd_dbg(dbg_reg_data),
    .we(rf_we_eff), .wa(rf_wa), .wd(wb_data)
  );

  assign alu_b = ctrl.b_imm ? ext_imm(f_imm, ctrl.ext_sign) : opb;

  sc_alu u_alu (
    .grp(ctrl.grp), .funct(f_funct), .a(opa), .b(alu_b),
    .res(alu_res), .zero(alu_zero), .fn_bad(alu_bad)
  );

  // data store: combinational read, edge write, word index from address bits
  assign d_idx     = alu_res[DA_W+1:2];
  assign mem_rdata = dmem[d_idx];
  always_ff @(posedge clk) begin
    if (ctrl.mem_we) dmem[d_idx] <= opb;
  end

  // writeback
  assign rf_wa     = ctrl.dst_rd ? f_rd : f_rt;
  assign rf_we_eff = ctrl.rf_we & ~alu_bad;
  assign wb_data   = ctrl.wb_mem ? mem_rdata : alu_res;

  // next PC
  assign pc4      = pc + XLEN'(4);
  assign br_dest  = br_target(pc4, f_imm);
  assign br_taken = ctrl.branch & alu_zero;
  assign pc_next  = br_taken ? br_dest : pc4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end

  assign dbg_pc = pc;

  p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !br_taken |=> (pc == $past(pc) + XLEN'(4)));

  p_pc_branch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |=> (pc == $past(br_dest)));

  p_single_writer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we_eff, ctrl.mem_we}));

  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.illegal |-> (!rf_we_eff && !ctrl.mem_we && !br_taken));
endmodule

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prog_we = 1'b0;
  logic [5:0]  prog_addr = '0;
  logic [31:0] prog_data = '0;
  logic [4:0]  dbg_reg_sel = '0;
  logic [31:0] dbg_reg_data, dbg_pc;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] prog [32];
  int          plen;

  always #2.5 clk = ~clk;

  sc_core u_sc_core (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .dbg_reg_sel(dbg_reg_sel),
    .dbg_reg_data(dbg_reg_data), .dbg_pc(dbg_pc)
  );

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'h00, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  localparam logic [31:0] HALT = {6'h04, 5'd0, 5'd0, 16'hFFFF};

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic put(input logic [31:0] w);
    prog[plen] = w;
    plen++;
  endtask

  task automatic boot(input int cycles);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = 6'(i); prog_data = prog[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic rd(input int idx, output logic [31:0] v);
    @(negedge clk);
    dbg_reg_sel = 5'(idx);
    #1;
    v = dbg_reg_data;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    plen = 0;
    put(enc_i(6'h0D, 0, 1, 16'h1234));
    put(HALT);
    boot(4);
    rd(1, v); chk("R4", "r1 before reset", v, 32'h0000_1234);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "pc in reset", dbg_pc, 32'h0);
    rd(1, v); chk("R1", "r1 in reset", v, 32'h0);
    rd(31, v); chk("R1", "r31 in reset", v, 32'h0);
  endtask

  task automatic t_alu;
    logic [31:0] v, a, b;
    a = 32'h0000_0F0F; b = 32'h0000_FFF0;
    plen = 0;
    put(enc_i(6'h0D, 0, 1, 16'h0F0F));
    put(enc_i(6'h0D, 0, 2, 16'hFFF0));
    put(enc_r(1, 2, 3, 6'h20));
    put(enc_r(1, 2, 4, 6'h22));
    put(enc_r(1, 2, 5, 6'h24));
    put(enc_r(1, 2, 6, 6'h25));
    put(enc_r(4, 1, 7, 6'h2A));
    put(enc_r(2, 4, 8, 6'h2A));
    put(HALT);
    boot(12);
    rd(2, v); chk("R4", "ori zero-extend", v, b);
    rd(3, v); chk("R2", "add", v, a + b);
    rd(4, v); chk("R2", "sub", v, a - b);
    rd(5, v); chk("R2", "and", v, a & b);
    rd(6, v); chk("R2", "or", v, a | b);
    rd(7, v); chk("R3", "slt negative<positive", v, ($signed(a - b) < $signed(a)) ? 32'd1 : 32'd0);
    rd(8, v); chk("R3", "slt positive<negative", v, ($signed(b) < $signed(a - b)) ? 32'd1 : 32'd0);
    chk("R2", "pc at halt", dbg_pc, 32'd8 * 4);
  endtask

  task automatic t_mem;
    logic [31:0] v, base;
    base = 32'h100;
    plen = 0;
    put(enc_i(6'h0D, 0, 1, 16'h0100));
    put(enc_i(6'h0D, 0, 2, 16'hBEEF));
    put(enc_i(6'h2B, 1, 2, 16'h2804));   // bits 15:11 name r5
    put(enc_i(6'h2B, 1, 1, 16'hFFFC));   // base - 4
    put(enc_i(6'h23, 1, 3, 16'h0004));   // aliases the 0x2804 store
    put(enc_i(6'h23, 1, 4, 16'hFFFC));
    put(HALT);
    boot(10);
    // word index 1 for both 0x2904 and 0x104 with a 64-word store
    chk("R5", "wrap index agrees", 32'(((base + 32'h2804) >> 2) % 64), 32'(((base + 32'h4) >> 2) % 64));
    rd(3, v); chk("R5", "load wrapped index", v, 32'h0000_BEEF);
    rd(4, v); chk("R5", "load negative offset", v, base);
    rd(5, v); chk("R6", "store leaves rd field reg", v, 32'h0);
    rd(2, v); chk("R6", "store leaves rt", v, 32'h0000_BEEF);
  endtask

  task automatic t_branch;
    logic [31:0] v;
    plen = 0;
    put(enc_i(6'h0D, 0, 1, 16'd5));
    put(enc_i(6'h0D, 0, 2, 16'd5));
    put(enc_i(6'h04, 1, 2, 16'd2));      // taken, skips two words
    put(enc_i(6'h0D, 0, 3, 16'd1));
    put(enc_i(6'h0D, 0, 4, 16'd1));
    put(enc_i(6'h0D, 0, 5, 16'd9));
    put(enc_i(6'h04, 1, 0, 16'd1));      // not taken
    put(enc_i(6'h0D, 0, 6, 16'd3));
    put(HALT);
    boot(12);
    rd(3, v); chk("R7", "skipped word 3", v, 32'h0);
    rd(4, v); chk("R7", "skipped word 4", v, 32'h0);
    rd(5, v); chk("R7", "taken target runs", v, 32'd9);
    rd(6, v); chk("R7", "fall-through runs", v, 32'd3);
    chk("R7", "halt holds pc", dbg_pc, 32'd8 << 2);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    plen = 0;
    put(enc_i(6'h0D, 0, 0, 16'h0055));
    put(enc_r(0, 0, 1, 6'h25));
    put(enc_i(6'h0D, 0, 2, 16'h0003));
    put(HALT);
    boot(6);
    rd(0, v); chk("R8", "r0 after write", v, 32'h0);
    rd(1, v); chk("R8", "r0 as operand", v, 32'h0);
    rd(2, v); chk("R8", "r0 base for ori", v, 32'h3);
  endtask

  task automatic t_same_cycle;
    logic [31:0] v, x;
    x = 32'd3;
    plen = 0;
    put(enc_i(6'h0D, 0, 1, 16'd3));
    put(enc_r(1, 1, 1, 6'h20));
    put(enc_r(1, 1, 1, 6'h20));
    put(enc_i(6'h0D, 0, 4, 16'h0040));
    put(enc_i(6'h2B, 4, 1, 16'h0000));
    put(enc_i(6'h23, 4, 5, 16'h0000));
    put(HALT);
    boot(10);
    x = x + x; x = x + x;
    rd(1, v); chk("R9", "chained self-add", v, x);
    rd(5, v); chk("R9", "load after store", v, x);
  endtask

  task automatic t_illegal;
    logic [31:0] v;
    plen = 0;
    put(enc_i(6'h0D, 0, 1, 16'd1));
    put(enc_i(6'h3F, 0, 1, 16'h1234));   // unknown opcode
    put(enc_r(1, 1, 2, 6'h3F));          // unlisted funct
    put(enc_i(6'h0D, 0, 3, 16'd7));
    put(HALT);
    boot(8);
    rd(1, v); chk("R10", "unknown op no write", v, 32'd1);
    rd(2, v); chk("R10", "unknown funct no write", v, 32'd0);
    rd(3, v); chk("R10", "pc advanced past", v, 32'd7);
  endtask

  initial begin
    t_reset();
    t_alu();
    t_mem();
    t_branch();
    t_zero();
    t_same_cycle();
    t_illegal();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule